// File: doc/BRIEF.md
# SPI Flash Identification and Status Responder

This block is the byte-level command responder of a serial NOR flash slave model. A separate shifter hands it each byte received on the host-to-device line, with a one-cycle strobe and the active-low chip select. It returns the byte to be shifted back to the host in the following byte slot. The block answers the JEDEC identification query, the read-status query and the two-byte manufacturer/device ID query. It also keeps a status register with a busy flag and a write-enable latch.

The manufacturer ID, device ID, block-protect field and busy flag come in on ports. The memory-type byte and the two fixed mode flags of the status byte are parameters. Storage for array reads, programs and erases is not part of this block.

Top module: `spi_flash_id_responder`

## Requirements
- R1: While reset is low, and in the cycle after it, `tx_byte` is 0xFF and the write-enable latch is clear.
- R2: After opcode 0x9F, the next three reply slots carry `mfr_id`, then `MEM_TYPE` (default 0x20), then `dev_id`. Every later slot in the same frame carries 0xFF.
- R3: After opcode 0x05, every reply slot carries the current status byte for as long as `cs_n` stays low.
- R4: The status byte is {SRWD_FLAG, CP_FLAG, bp_bits[3:0], write-enable latch, busy}, with bit 0 = busy and bit 7 = SRWD_FLAG.
- R5: After opcode 0x90, the reply slots for the two dummy bytes and for the selector byte carry 0xFF.
- R6: A selector of 0x00 makes the next two slots `mfr_id` then `dev_id`. Any other selector value, 0x01 included, gives `dev_id` then `mfr_id`. After those two slots, 0xFF follows.
- R7: Any clock edge with `cs_n` high ends the sequence in progress and sets `tx_byte` to 0xFF. The first byte of the next frame is decoded as an opcode.
- R8: Opcode 0x06 sets the write-enable latch, but only when `cs_n` next goes high. The latch never changes while `cs_n` is low.
- R9: Opcode 0x04 clears the write-enable latch when `cs_n` next goes high. An unknown opcode replies 0xFF and leaves the latch unchanged.
- R10: `tx_byte` changes only on a strobe received with `cs_n` low, or on deselect. A strobe while `cs_n` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select |
| rx_valid | input | 1 | One-cycle strobe: `rx_byte` holds a received byte |
| rx_byte | input | 8 | Byte received from the host |
| mfr_id | input | 8 | Manufacturer ID to report |
| dev_id | input | 8 | Device ID to report |
| bp_bits | input | 4 | Block-protect field of the status byte |
| busy | input | 1 | Write-in-progress flag of the status byte |
| tx_byte | output | 8 | Byte to be shifted out in the next slot |

## Verification
On every cycle, the assertions check these rules:
- A deselect forces 0xFF.
- The write-enable latch holds still inside a frame.
- The reply byte holds while no strobe arrives.
- During a status read, each reply carries the block-protect and busy inputs sampled at the strobe.

Only the bench's scenarios show that the reply orders are right: the JEDEC triple, the selector-driven swap of the two IDs, 0xFF after a finished sequence, and latch changes that appear only in the next frame's status read. The bench covers these by comparing a reference model against the output on every clock.

// File: rtl/spi_flash_id_responder.sv
module spi_flash_id_responder #(
  parameter logic [7:0] MEM_TYPE  = 8'h20,
  parameter bit         CP_FLAG   = 1'b0,
  parameter bit         SRWD_FLAG = 1'b0,
  parameter logic [7:0] OP_JEDEC  = 8'h9F,
  parameter logic [7:0] OP_STATUS = 8'h05,
  parameter logic [7:0] OP_IDPAIR = 8'h90,
  parameter logic [7:0] OP_WREN   = 8'h06,
  parameter logic [7:0] OP_WRDI   = 8'h04,
  parameter logic [7:0] IDLE_BYTE = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic [7:0] mfr_id,
  input  logic [7:0] dev_id,
  input  logic [3:0] bp_bits,
  input  logic       busy,
  output logic [7:0] tx_byte
);

  typedef enum logic [2:0] {
    S_OPC, S_JID, S_STAT, S_DUMMY, S_SEL, S_IDS, S_DONE
  } state_t;

  typedef enum logic [1:0] {P_NONE, P_SET, P_CLR} pend_t;

  state_t      state;
  pend_t       pend;
  logic [1:0]  idx;
  logic        dev_first;
  logic        wel;
  logic        rdsr_active;
  logic [7:0]  status;
  logic [7:0]  first_id, second_id;

  assign status      = {SRWD_FLAG, CP_FLAG, bp_bits, wel, busy};
  assign rdsr_active = (state == S_STAT);
  assign first_id    = dev_first ? dev_id : mfr_id;
  assign second_id   = dev_first ? mfr_id : dev_id;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_OPC;
      pend      <= P_NONE;
      idx       <= 2'd0;
      dev_first <= 1'b0;
      wel       <= 1'b0;
      tx_byte   <= IDLE_BYTE;
    end else if (cs_n) begin
      state   <= S_OPC;
      idx     <= 2'd0;
      tx_byte <= IDLE_BYTE;
      pend    <= P_NONE;
      if (pend == P_SET) wel <= 1'b1;
      else if (pend == P_CLR) wel <= 1'b0;
    end else if (rx_valid) begin
      case (state)
        S_OPC: begin
          idx <= 2'd0;
          if (rx_byte == OP_JEDEC) begin
            state   <= S_JID;
            tx_byte <= mfr_id;
          end else if (rx_byte == OP_STATUS) begin
            state   <= S_STAT;
            tx_byte <= status;
          end else if (rx_byte == OP_IDPAIR) begin
            state   <= S_DUMMY;
            tx_byte <= IDLE_BYTE;
          end else begin
            state   <= S_DONE;
            tx_byte <= IDLE_BYTE;
            if (rx_byte == OP_WREN) pend <= P_SET;
            else if (rx_byte == OP_WRDI) pend <= P_CLR;
          end
        end
        S_JID: begin
          idx <= idx + 2'd1;
          if (idx == 2'd0) tx_byte <= MEM_TYPE;
          else if (idx == 2'd1) tx_byte <= dev_id;
          else begin
            state   <= S_DONE;
            tx_byte <= IDLE_BYTE;
          end
        end
        S_STAT: tx_byte <= status;
        S_DUMMY: begin
          tx_byte <= IDLE_BYTE;
          if (idx == 2'd1) begin
            state <= S_SEL;
            idx   <= 2'd0;
          end else begin
            idx <= idx + 2'd1;
          end
        end
        S_SEL: begin
          dev_first <= (rx_byte != 8'h00);
          tx_byte   <= (rx_byte != 8'h00) ? dev_id : mfr_id;
          state     <= S_IDS;
          idx       <= 2'd0;
        end
        S_IDS: begin
          if (idx == 2'd0) begin
            tx_byte <= second_id;
            idx     <= 2'd1;
          end else begin
            tx_byte <= IDLE_BYTE;
            state   <= S_DONE;
          end
        end
        default: tx_byte <= IDLE_BYTE;
      endcase
    end
  end

endmodule

// File: rtl/spi_flash_id_responder_chk.sv
module spi_flash_id_responder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       rx_valid,
  input logic [3:0] bp_bits,
  input logic       busy,
  input logic [7:0] tx_byte,
  input logic       wel,
  input logic       rdsr_active
);

  AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (tx_byte == 8'hFF)); // R7

  AST_WEL_FRAME_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |=> $stable(wel)); // R8

  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !rx_valid) |=> $stable(tx_byte)); // R10

  AST_STATUS_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && rx_valid && rdsr_active) |=>
      (tx_byte[5:2] == $past(bp_bits) && tx_byte[0] == $past(busy))); // R4

endmodule

bind spi_flash_id_responder spi_flash_id_responder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid),
  .bp_bits(bp_bits), .busy(busy), .tx_byte(tx_byte), .wel(wel),
  .rdsr_active(rdsr_active)
);

// File: tb/spi_flash_id_responder_test.sv
module spi_flash_id_responder_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic [7:0] mfr_id = 8'hC2;
  logic [7:0] dev_id = 8'h17;
  logic [3:0] bp_bits = 4'b1010;
  logic       busy = 1'b0;
  logic [7:0] tx_byte;

  spi_flash_id_responder #(.CP_FLAG(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .mfr_id(mfr_id), .dev_id(dev_id),
    .bp_bits(bp_bits), .busy(busy), .tx_byte(tx_byte)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit running = 1'b0;
  string req = "R1";

  logic [7:0] exp_tx = 8'hFF;
  bit         m_wel = 1'b0;
  bit         m_first = 1'b1;
  bit         m_stat = 1'b0;
  int         m_rems = 0;
  int         m_pend = -1;
  logic [7:0] m_q[$];

  function automatic logic [7:0] exp_status();
    return {1'b0, 1'b1, bp_bits, m_wel, busy};
  endfunction

  task automatic check(string r, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h at %0t", r, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (running) check(req, tx_byte, exp_tx);
    if (cycles > 50000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic send(logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_byte  = b;
    @(posedge clk);
    #1 rx_valid = 1'b0;
    if (!cs_n) begin
      if (m_first) begin
        m_first = 1'b0;
        case (b)
          8'h9F: m_q = '{mfr_id, 8'h20, dev_id};
          8'h05: m_stat = 1'b1;
          8'h90: m_rems = 3;
          8'h06: m_pend = 1;
          8'h04: m_pend = 0;
          default: ;
        endcase
      end else if (m_rems > 0) begin
        m_rems--;
        if (m_rems == 0)
          m_q = (b == 8'h00) ? '{mfr_id, dev_id} : '{dev_id, mfr_id};
      end
      if (m_stat) exp_tx = exp_status();
      else if (m_q.size() > 0) exp_tx = m_q.pop_front();
      else exp_tx = 8'hFF;
    end
  endtask

  task automatic deselect();
    @(negedge clk);
    cs_n = 1'b1;
    @(posedge clk);
    #1;
    if (m_pend == 1) m_wel = 1'b1;
    else if (m_pend == 0) m_wel = 1'b0;
    m_pend = -1; m_first = 1'b1; m_stat = 1'b0; m_rems = 0; m_q = {};
    exp_tx = 8'hFF;
  endtask

  task automatic select();
    @(negedge clk);
    cs_n = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", tx_byte, 8'hFF);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", tx_byte, 8'hFF);
    running = 1'b1;

    req = "R2"; select(); send(8'h9F);
    for (int i = 0; i < 5; i++) send(8'h00);
    deselect();

    req = "R4"; select(); send(8'h05); send(8'h00);
    check("R1", tx_byte[1], 1'b0);
    deselect();

    req = "R3"; select(); send(8'h05);
    for (int i = 0; i < 3; i++) send(8'hAA);
    busy = 1'b1; bp_bits = 4'b0101;
    send(8'hAA); send(8'hAA);
    busy = 1'b0;
    deselect();

    req = "R6"; select(); send(8'h90); send(8'h00); send(8'h00); send(8'h00);
    send(8'h00); send(8'h00); send(8'h00);
    deselect();
    req = "R6"; select(); send(8'h90); send(8'h00); send(8'h00); send(8'h01);
    send(8'h00); send(8'h00); send(8'h00);
    deselect();
    req = "R5"; select(); send(8'h90); send(8'h12); send(8'h34); send(8'h07);
    send(8'h00); send(8'h00);
    deselect();

    req = "R8"; select(); send(8'h06); send(8'h00); deselect();
    select(); send(8'h05); send(8'h00);
    check("R8", tx_byte[1], 1'b1);
    deselect();

    req = "R9"; select(); send(8'h3B); send(8'h00); deselect();
    select(); send(8'h05);
    check("R9", tx_byte[1], 1'b1);
    deselect();
    select(); send(8'h04); deselect();
    select(); send(8'h05);
    check("R9", tx_byte[1], 1'b0);
    deselect();

    req = "R7"; select(); send(8'h9F); send(8'h00); deselect();
    select(); send(8'h05); send(8'h00); deselect();

    req = "R10"; send(8'h9F);
    check("R10", tx_byte, 8'hFF);
    select(); send(8'h05);
    repeat (4) @(negedge clk);
    deselect();

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule